// File: doc/BRIEF.md
# Sparse Serial Hit Readout

This block drains the per-channel hit buffers of a 128-channel front end, one event at a time, onto a single serial line. Each accepted trigger takes a wrapping event number and records the event time it arrives with. The pair waits in a small pending-event queue. While the read enable is high and an event is pending, the block sends one frame for it.

A frame opens with a header word that holds a start code, the event number and the event time. It then scans the channel flags from the lowest channel upward. It sends a record only for a channel whose non-empty flag is set, and it skips every other channel without spending a cycle on it. A trailer word closes the frame and carries the number of records sent. As the last bit of a record leaves the block, it pulses a pop to the channel that record came from. Triggers are still accepted while a frame is shifting, so acquisition and readout overlap.

Top module: `sparse_serial_readout`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, `frame_o`, `sdo_o` and every bit of `ch_pop_o` are low.
- R2: A frame starts only in a cycle that follows an edge at which `en_i` was high and an event was pending. While `en_i` stays low, pending events wait and nothing is sent.
- R3: A frame sends one bit per clock, MSB first. `frame_o` is high for exactly the frame's bits. `sdo_o` is low whenever `frame_o` is low. Two frames are separated by at least one low cycle. The header is 20 bits: the start code 4'b1101, the 8-bit event number, then the 8-bit event time.
- R4: Only channels whose `ch_hit_i` bit is set produce a record, and records appear in ascending channel order.
- R5: A record is 17 bits: a tag bit of 1, the 7-bit channel number, the channel's 5-bit timestamp, then its 4-bit pulse-width code.
- R6: The trailer is 9 bits: a tag bit of 0, then the 8-bit count of records in the frame. An event with no hits gives a header followed by a trailer, and an event with all 128 channels hit gives a count of 128.
- R7: During the last bit of each record, `ch_pop_o` is one-hot on that record's channel, for that single cycle. At every other time it is zero.
- R8: Every trigger advances an 8-bit event number that wraps from 255 to 0. Events are read out in trigger order.
- R9: The queue holds up to 4 pending events. A trigger that arrives while 4 are pending is dropped, but it still uses up an event number.
- R10: Triggers that arrive while a frame is shifting are queued, and they are sent after that frame ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the serial bit clock |
| rst | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Allows a new frame to start |
| trig_i | input | 1 | Accepted-trigger pulse, one cycle per event |
| trig_time_i | input | 8 | Event time captured with the trigger |
| ch_hit_i | input | 128 | Per-channel buffer non-empty flags |
| ch_ts_i | input | 640 | Per-channel 5-bit hit timestamp, channel c at bits [5c+4:5c] |
| ch_tot_i | input | 512 | Per-channel 4-bit pulse-width code, channel c at bits [4c+3:4c] |
| ch_pop_o | output | 128 | One-cycle pop to the channel whose record just finished |
| sdo_o | output | 1 | Serial data, MSB first |
| frame_o | output | 1 | High for every bit of a frame |

## Verification
The bench aims at the boundary channels 0 and 127. A finder that starts from the wrong index, or that fails to stop at the top of the range, would drop those records or repeat them. It also sends an empty event and a fully hit event. A trailer counter that is too narrow or reset at the wrong time would report the wrong count there. It fills the pending queue past its depth while reading is held off, and it runs the event number through its wrap. A design that loses or renumbers events shows a wrong header in a later frame. Every serial bit is compared against a scoreboard, and the pop is compared bit by bit as well. A pop that comes one cycle early or late, or a frame strobe that lasts one bit too many, therefore fails at the exact bit where it happens.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_HDR  = 2'd1,
    PH_REC  = 2'd2,
    PH_TRL  = 2'd3
  } phase_t;

  localparam logic [3:0] START_CODE = 4'b1101;
  localparam logic       REC_TAG    = 1'b1;
  localparam logic       TRL_TAG    = 1'b0;
endpackage

// File: rtl/ssr_event_queue.sv
module ssr_event_queue #(
  parameter int DEPTH = 4,
  parameter int EVN_W = 8,
  parameter int ET_W  = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [ET_W-1:0]  push_time,
  input  logic             pop,
  output logic [EVN_W-1:0] head_evn,
  output logic [ET_W-1:0]  head_time,
  output logic             empty,
  output logic [CW-1:0]    count
);
  logic [EVN_W-1:0] evn_mem  [DEPTH];
  logic [ET_W-1:0]  time_mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [EVN_W-1:0] evn_ctr;
  logic [CW-1:0]    cnt;
  logic             accept, take;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign accept = push && (cnt != CW'(DEPTH));
  assign take   = pop && (cnt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      cnt     <= '0;
      evn_ctr <= '0;
    end else begin
      if (push) evn_ctr <= evn_ctr + EVN_W'(1);
      if (accept) begin
        evn_mem[wr_ptr]  <= evn_ctr;
        time_mem[wr_ptr] <= push_time;
        wr_ptr           <= bump(wr_ptr);
      end
      if (take) rd_ptr <= bump(rd_ptr);
      cnt <= cnt + CW'(accept) - CW'(take);
    end
  end

  assign head_evn  = evn_mem[rd_ptr];
  assign head_time = time_mem[rd_ptr];
  assign empty     = (cnt == '0);
  assign count     = cnt;
endmodule

// File: rtl/ssr_hit_finder.sv
module ssr_hit_finder #(
  parameter int NUM_CH = 128,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic [NUM_CH-1:0] hits,
  input  logic [CH_W:0]     from,
  output logic              found,
  output logic [CH_W-1:0]   idx
);
  logic [NUM_CH-1:0] mask, cand;

  always_comb begin
    mask  = '1;
    mask  = mask << from;
    cand  = hits & mask;
    found = |cand;
    idx   = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (cand[i]) idx = CH_W'(i);
    end
  end
endmodule

// File: rtl/ssr_serializer.sv
module ssr_serializer #(
  parameter int SH_W  = 20,
  localparam int LEN_W = $clog2(SH_W + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [SH_W-1:0]  word,
  input  logic [LEN_W-1:0] len,
  output logic             sdo,
  output logic             last
);
  logic [SH_W-1:0]  sh;
  logic [LEN_W-1:0] left;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh   <= '0;
      left <= '0;
    end else if (load) begin
      sh   <= word;
      left <= len;
    end else if (left != '0) begin
      sh   <= sh << 1;
      left <= left - LEN_W'(1);
    end
  end

  assign sdo  = (left != '0) && sh[SH_W-1];
  assign last = (left == LEN_W'(1));
endmodule

// File: rtl/sparse_serial_readout.sv
module sparse_serial_readout
  import ssr_pkg::*;
#(
  parameter int NUM_CH    = 128,
  parameter int TS_W      = 5,
  parameter int TOT_W     = 4,
  parameter int EVN_W     = 8,
  parameter int ET_W      = 8,
  parameter int EVQ_DEPTH = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en_i,
  input  logic                    trig_i,
  input  logic [ET_W-1:0]         trig_time_i,
  input  logic [NUM_CH-1:0]       ch_hit_i,
  input  logic [NUM_CH*TS_W-1:0]  ch_ts_i,
  input  logic [NUM_CH*TOT_W-1:0] ch_tot_i,
  output logic [NUM_CH-1:0]       ch_pop_o,
  output logic                    sdo_o,
  output logic                    frame_o
);
  localparam int CH_W    = $clog2(NUM_CH);
  localparam int CNT_W   = $clog2(NUM_CH + 1);
  localparam int HDR_LEN = 4 + EVN_W + ET_W;
  localparam int REC_LEN = 1 + CH_W + TS_W + TOT_W;
  localparam int TRL_LEN = 1 + CNT_W;
  localparam int SH_A    = (HDR_LEN > REC_LEN) ? HDR_LEN : REC_LEN;
  localparam int SH_W    = (SH_A > TRL_LEN) ? SH_A : TRL_LEN;
  localparam int LEN_W   = $clog2(SH_W + 1);
  localparam int QCW     = $clog2(EVQ_DEPTH + 1);
  localparam logic [NUM_CH-1:0] ONE_HOT0 = NUM_CH'(1);

  // word builders: each field is placed MSB first, left-justified in the shifter
  function automatic logic [SH_W-1:0] pack_header(input logic [EVN_W-1:0] evn,
                                                  input logic [ET_W-1:0] et);
    logic [HDR_LEN-1:0] w;
    w = {START_CODE, evn, et};
    return SH_W'(w) << (SH_W - HDR_LEN);
  endfunction

  function automatic logic [SH_W-1:0] pack_record(input logic [CH_W-1:0] ch,
                                                  input logic [TS_W-1:0] ts,
                                                  input logic [TOT_W-1:0] tot);
    logic [REC_LEN-1:0] w;
    w = {REC_TAG, ch, ts, tot};
    return SH_W'(w) << (SH_W - REC_LEN);
  endfunction

  function automatic logic [SH_W-1:0] pack_trailer(input logic [CNT_W-1:0] n);
    logic [TRL_LEN-1:0] w;
    w = {TRL_TAG, n};
    return SH_W'(w) << (SH_W - TRL_LEN);
  endfunction

  phase_t            phase, nxt;
  logic [CH_W-1:0]   cur_ch;
  logic [CNT_W-1:0]  hit_cnt;
  logic              q_empty, q_pop;
  logic [EVN_W-1:0]  q_evn;
  logic [ET_W-1:0]   q_time;
  logic [QCW-1:0]    evq_count;
  logic [CH_W:0]     scan_from;
  logic              f_found;
  logic [CH_W-1:0]   f_idx;
  logic [TS_W-1:0]   f_ts;
  logic [TOT_W-1:0]  f_tot;
  logic              ld, ld_hdr, ld_rec;
  logic [SH_W-1:0]   ld_word;
  logic [LEN_W-1:0]  ld_len;
  logic              word_done;
  logic              trl_done;

  ssr_event_queue #(
    .DEPTH(EVQ_DEPTH), .EVN_W(EVN_W), .ET_W(ET_W)
  ) u_evq (
    .clk(clk), .rst(rst),
    .push(trig_i), .push_time(trig_time_i), .pop(q_pop),
    .head_evn(q_evn), .head_time(q_time),
    .empty(q_empty), .count(evq_count)
  );

  assign scan_from = (phase == PH_REC) ? ({1'b0, cur_ch} + (CH_W+1)'(1)) : '0;

  ssr_hit_finder #(.NUM_CH(NUM_CH)) u_find (
    .hits(ch_hit_i), .from(scan_from), .found(f_found), .idx(f_idx)
  );

  assign f_ts  = ch_ts_i[f_idx*TS_W +: TS_W];
  assign f_tot = ch_tot_i[f_idx*TOT_W +: TOT_W];

  ssr_serializer #(.SH_W(SH_W)) u_ser (
    .clk(clk), .rst(rst), .load(ld), .word(ld_word), .len(ld_len),
    .sdo(sdo_o), .last(word_done)
  );

  always_comb begin
    nxt     = phase;
    ld      = 1'b0;
    ld_hdr  = 1'b0;
    ld_rec  = 1'b0;
    ld_word = '0;
    ld_len  = '0;
    q_pop   = 1'b0;
    unique case (phase)
      PH_IDLE: begin
        if (en_i && !q_empty) begin
          ld      = 1'b1;
          ld_hdr  = 1'b1;
          ld_word = pack_header(q_evn, q_time);
          ld_len  = LEN_W'(HDR_LEN);
          q_pop   = 1'b1;
          nxt     = PH_HDR;
        end
      end
      PH_HDR, PH_REC: begin
        if (word_done) begin
          ld = 1'b1;
          if (f_found) begin
            ld_rec  = 1'b1;
            ld_word = pack_record(f_idx, f_ts, f_tot);
            ld_len  = LEN_W'(REC_LEN);
            nxt     = PH_REC;
          end else begin
            ld_word = pack_trailer(hit_cnt);
            ld_len  = LEN_W'(TRL_LEN);
            nxt     = PH_TRL;
          end
        end
      end
      PH_TRL: begin
        if (word_done) nxt = PH_IDLE;
      end
      default: nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_IDLE;
      cur_ch  <= '0;
      hit_cnt <= '0;
    end else begin
      phase <= nxt;
      if (ld_hdr)      hit_cnt <= '0;
      else if (ld_rec) hit_cnt <= hit_cnt + CNT_W'(1);
      if (ld_rec) cur_ch <= f_idx;
    end
  end

  assign trl_done = (phase == PH_TRL) && word_done;
  assign ch_pop_o = (phase == PH_REC && word_done) ? (ONE_HOT0 << cur_ch) : '0;
  assign frame_o  = (phase != PH_IDLE);
endmodule

// File: rtl/ssr_checker.sv
module ssr_checker #(
  parameter int NUM_CH = 128,
  parameter int DEPTH  = 4,
  parameter int QCW    = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              en_i,
  input logic [NUM_CH-1:0] ch_hit_i,
  input logic [NUM_CH-1:0] ch_pop_o,
  input logic              sdo_o,
  input logic              frame_o,
  input logic              trl_done,
  input logic [QCW-1:0]    evq_count
);
  p_pop_onehot_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ch_pop_o));

  p_pop_hit_r7: assert property (@(posedge clk) disable iff (rst)
    (ch_pop_o != '0) |-> ((ch_pop_o & ch_hit_i) != '0));

  p_pop_in_frame_r7: assert property (@(posedge clk) disable iff (rst)
    (ch_pop_o != '0) |-> frame_o);

  p_start_enabled_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(frame_o) |-> $past(en_i));

  p_end_on_trailer_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(frame_o) |-> $past(trl_done));

  p_quiet_line_r3: assert property (@(posedge clk) disable iff (rst)
    !frame_o |-> !sdo_o);

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
    evq_count <= QCW'(DEPTH));
endmodule

bind sparse_serial_readout ssr_checker #(
  .NUM_CH(NUM_CH), .DEPTH(EVQ_DEPTH), .QCW(QCW)
) u_chk (
  .clk(clk), .rst(rst), .en_i(en_i), .ch_hit_i(ch_hit_i),
  .ch_pop_o(ch_pop_o), .sdo_o(sdo_o), .frame_o(frame_o),
  .trl_done(trl_done), .evq_count(evq_count)
);

// File: tb/sparse_serial_readout_test.sv
module sparse_serial_readout_test;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int NUM_CH = 128;
  localparam int TS_W   = 5;
  localparam int TOT_W  = 4;

  logic clk = 1'b0, rst = 1'b1, en = 1'b0, trig = 1'b0;
  logic [7:0]              ttime = '0;
  logic [NUM_CH-1:0]       hit   = '0;
  logic [NUM_CH*TS_W-1:0]  ts    = '0;
  logic [NUM_CH*TOT_W-1:0] tot   = '0;
  wire  [NUM_CH-1:0]       pop;
  wire                     sdo, frame;

  sparse_serial_readout uut (
    .clk(clk), .rst(rst), .en_i(en), .trig_i(trig), .trig_time_i(ttime),
    .ch_hit_i(hit), .ch_ts_i(ts), .ch_tot_i(tot),
    .ch_pop_o(pop), .sdo_o(sdo), .frame_o(frame)
  );

  always #2.5 clk = ~clk;

  typedef struct {
    bit    b;
    int    pop_ch;
    bit    first;
    bit    last;
    string req;
  } item_t;

  item_t exp_q[$];
  int checks = 0, fails = 0, evn_model = 0, frames_seen = 0, frames_exp = 0;
  bit prev_frame = 0, prev_last = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic int pop_idx(input logic [NUM_CH-1:0] v);
    if (v == '0) return -1;
    if ($countones(v) != 1) return -2;
    for (int i = 0; i < NUM_CH; i++) if (v[i]) return i;
    return -2;
  endfunction

  // driver side of the scoreboard: push the bits a frame must contain
  task automatic push_field(input int val, input int w, input string req,
                            input int popc, input bit first, input bit last);
    for (int i = w - 1; i >= 0; i--) begin
      item_t it;
      it.b      = val[i];
      it.pop_ch = (i == 0) ? popc : -1;
      it.first  = first && (i == w - 1);
      it.last   = last && (i == 0);
      it.req    = req;
      exp_q.push_back(it);
    end
  endtask

  task automatic expect_frame(input int evn, input int et);
    int n = 0;
    push_field(13, 4, "R3", -1, 1, 0);
    push_field(evn % 256, 8, "R8", -1, 0, 0);
    push_field(et, 8, "R3", -1, 0, 0);
    for (int c = 0; c < NUM_CH; c++) begin
      if (hit[c]) begin
        push_field(1, 1, "R4", -1, 0, 0);
        push_field(c, 7, "R5", -1, 0, 0);
        push_field(int'(ts[c*TS_W +: TS_W]), TS_W, "R5", -1, 0, 0);
        push_field(int'(tot[c*TOT_W +: TOT_W]), TOT_W, "R7", c, 0, 0);
        n++;
      end
    end
    push_field(0, 1, "R6", -1, 0, 0);
    push_field(n, 8, "R6", -1, 0, 1);
    frames_exp++;
  endtask

  task automatic fire(input int et, input bit expect_it);
    int e;
    e = evn_model;
    @(negedge clk);
    ttime = 8'(et);
    trig  = 1'b1;
    @(negedge clk);
    trig  = 1'b0;
    evn_model++;
    if (expect_it) expect_frame(e, et);
  endtask

  task automatic drain(input string req);
    for (int c = 0; c < 20000 && (exp_q.size() != 0 || frame); c++) @(negedge clk);
    @(negedge clk);
    check(exp_q.size() == 0, req, "bits still expected", exp_q.size(), 0);
  endtask

  // monitor side of the scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      bit this_last;
      this_last = 0;
      if (prev_last) check(!frame, "R3", "strobe after last bit", frame, 0);
      if (frame) begin
        if (exp_q.size() == 0) begin
          check(0, "R2", "unexpected frame bit", 1, 0);
        end else begin
          item_t it;
          it = exp_q.pop_front();
          check(sdo == it.b, it.req, "serial bit", sdo, it.b);
          check(pop_idx(pop) == it.pop_ch, "R7", "pop channel", pop_idx(pop), it.pop_ch);
          if (it.first) begin
            frames_seen++;
            check(!prev_frame, "R3", "gap before frame", prev_frame, 0);
          end
          this_last = it.last;
        end
      end else begin
        if (pop != '0) check(0, "R7", "pop outside frame", pop_idx(pop), -1);
        if (sdo) check(0, "R3", "data outside frame", sdo, 0);
      end
      prev_frame = frame;
      prev_last  = this_last;
    end
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "R2", "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    for (int c = 0; c < NUM_CH; c++) begin
      ts[c*TS_W +: TS_W]    = TS_W'((c * 7 + 3) % 32);
      tot[c*TOT_W +: TOT_W] = TOT_W'((c * 5 + 1) % 16);
    end
    repeat (4) @(negedge clk);
    check(frame == 0, "R1", "frame in reset", frame, 0);
    check(sdo == 0, "R1", "sdo in reset", sdo, 0);
    check(pop == '0, "R1", "pop in reset", pop_idx(pop), -1);
    rst = 1'b0;
    @(negedge clk);
    check(frame == 0 && sdo == 0, "R1", "idle after reset", frame, 0);

    // R2: pending event held while read enable is low
    hit = '0;
    hit[3] = 1'b1;
    fire(8'h21, 0);
    repeat (40) @(negedge clk);
    check(frames_seen == 0, "R2", "frame while disabled", frames_seen, 0);
    expect_frame(0, 8'h21);
    en = 1'b1;
    drain("R2");
    check(frames_seen == 1, "R2", "frame after enable", frames_seen, 1);

    // R4 R5: boundary channels
    hit = '0;
    hit[0] = 1'b1;
    hit[127] = 1'b1;
    fire(8'h5A, 1);
    drain("R4");

    // R6: empty event
    hit = '0;
    fire(8'hC3, 1);
    drain("R6");

    // R6: every channel hit, count 128
    hit = '1;
    fire(8'h7E, 1);
    drain("R6");

    // R4 R5: scattered hits with new record data
    hit = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (c % 9 == 4 || c == 64) hit[c] = 1'b1;
      ts[c*TS_W +: TS_W]    = TS_W'((c * 13 + 11) % 32);
      tot[c*TOT_W +: TOT_W] = TOT_W'((c * 3 + 9) % 16);
    end
    fire(8'h0F, 1);
    drain("R5");

    // R10: trigger during a frame
    hit = '0;
    hit[10] = 1'b1;
    hit[90] = 1'b1;
    fire(8'h11, 1);
    repeat (12) @(negedge clk);
    check(frame == 1, "R10", "frame in progress", frame, 1);
    fire(8'h12, 1);
    drain("R10");

    // R9: overflow of the pending queue
    hit = '0;
    en  = 1'b0;
    repeat (3) @(negedge clk);
    for (int k = 0; k < 5; k++) fire(8'h40 + k, k < 4);
    repeat (5) @(negedge clk);
    en = 1'b1;
    drain("R9");
    fire(8'h99, 1);
    drain("R9");
    check(frames_seen == frames_exp, "R9", "frame count", frames_seen, frames_exp);

    // R8: event number wraps past 255
    while (evn_model < 262) begin
      fire(evn_model % 256, 1);
      drain("R8");
    end
    check(frames_seen == frames_exp, "R8", "frames after wrap", frames_seen, frames_exp);
    summary();
  end
endmodule